// File: doc/BRIEF.md
# Dual-Modulus Swallow Counter Controller

This block sits behind an external two-ratio prescaler and is clocked by that prescaler's output. It counts prescaler output pulses in cycles of a programmable length and drives a modulus-control line back to the prescaler. The line is low for the first part of each cycle and high for the rest. The prescaler divides by P+1 while the line is low and by P while it is high, so the whole VCO-to-output ratio is N·P + A. Once per cycle the block issues a one-clock divided output pulse, which feeds a phase comparator.

The swallow count (7 bits) and the main count (14 bits) arrive as shadow values. They move into the active registers on a load request. In asynchronous mode the copy happens on the very next edge. In synchronous mode the request is held pending and the copy is made only when the cycle counter stands at one, just past the wrap. A channel change then never splits a cycle in an arbitrary place. A load-done strobe marks the clock in which the new values are first active.

A single-ratio mode holds the modulus line low and divides by the main count alone. A standby input freezes the sequencer at the cycle start with every output low. The modulus line can be issued from the rising edge of the clock or delayed to the following falling edge, to meet the prescaler's switching window.

Top module: `swc_ctrl`

## Requirements
- R1: After reset the modulus line, divided output and load-done strobe are low, the active swallow count is 0 and the active main count is 3, so a free-running single-mode block pulses the divided output every 3 clocks.
- R2: In dual mode with active counts A and N (A < N), each cycle lasts N clocks. The divided output is high in the first clock of a cycle. The modulus line is low for the first A clocks of the cycle, counting that pulse clock, and high for the remaining N−A clocks.
- R3: With an active swallow count of 0 in dual mode, the modulus line stays high in every clock of every cycle.
- R4: With dual mode off (dual_en = 0), the modulus line is low and the divided output pulses every N clocks.
- R5: While standby is high, the modulus line and divided output are low and the cycle counter is held at its start. After standby falls, the first divided pulse comes N clocks later.
- R6: With edge_fall = 0 the modulus line changes right after the rising clock edge. With edge_fall = 1 it shows the same value half a clock later, from the falling edge.
- R7: With sync_en = 0, a load request copies the shadow values on the next rising edge. load_done is high for the following clock, and the new counts govern the cycle from that clock on.
- R8: With sync_en = 1, a load request is held until the cycle counter reads one (the second clock of a cycle) and standby is low. The copy happens on that edge, and load_done is high in the third clock of the cycle.
- R9: A shadow main count below 3 is loaded as 3.
- R10: If an asynchronous load makes the active main count smaller than the current position in the cycle, the cycle wraps on the next clock and emits its divided pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_shadow | input | 7 | Shadow swallow count A |
| n_shadow | input | 14 | Shadow main count N |
| dual_en | input | 1 | 1 = two-ratio operation, 0 = single ratio |
| edge_fall | input | 1 | 1 = issue modulus from the falling edge |
| standby | input | 1 | Freeze sequencer, outputs low |
| sync_en | input | 1 | 1 = synchronous reload at count one |
| load_req | input | 1 | One-clock request to load the shadow values |
| mod_out | output | 1 | Modulus control to the prescaler |
| div_out | output | 1 | Divided output pulse, one per cycle |
| load_done | output | 1 | High in the clock the new counts first apply |

## Verification
The hardest situations to reach are the reload corner cases. One is a synchronous request held across a standby interval, where the counter never reaches one. The other is an asynchronous load that shrinks the main count below the counter's current position. The stimulus reaches the first by raising standby right after a synchronous request and releasing it many clocks later. It reaches the second by loading a long cycle, waiting until the counter is deep into it, and then loading a short one. A behavioural reference model checks the modulus line both before and after the falling edge in every clock, so a half-clock shift of the wrong edge shows up at once.

// File: rtl/swc_pkg.sv
package swc_pkg;
    parameter int SWC_A_W   = 7;
    parameter int SWC_N_W   = 14;
    parameter int SWC_N_MIN = 3;

    typedef struct packed {
        logic [SWC_A_W-1:0] a;
        logic [SWC_N_W-1:0] n;
        logic               pend;
        logic               done;
    } reload_t;

    typedef struct packed {
        logic [SWC_N_W-1:0] cnt;
        logic               div;
        logic               mod;
    } seq_t;
endpackage

// File: rtl/swc_reload.sv
module swc_reload
    import swc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SWC_A_W-1:0] a_shadow,
    input  logic [SWC_N_W-1:0] n_shadow,
    input  logic               sync_en,
    input  logic               load_req,
    input  logic               standby,
    input  logic [SWC_N_W-1:0] cnt_q,
    output logic [SWC_A_W-1:0] a_act,
    output logic [SWC_N_W-1:0] n_act,
    output logic [SWC_A_W-1:0] a_nxt,
    output logic               load_done
);
    localparam logic [SWC_N_W-1:0] NMIN = SWC_N_W'(SWC_N_MIN);
    localparam logic [SWC_N_W-1:0] SAFE_PT = SWC_N_W'(1);

    reload_t r_q, r_d;
    logic [SWC_N_W-1:0] n_in;
    logic               xfer;

    always_comb begin
        n_in = (n_shadow < NMIN) ? NMIN : n_shadow;
        if (sync_en) begin
            xfer = r_q.pend && !standby && (cnt_q == SAFE_PT);
        end else begin
            xfer = load_req;
        end
        r_d      = r_q;
        r_d.done = xfer;
        r_d.pend = sync_en && (load_req || (r_q.pend && !xfer));
        if (xfer) begin
            r_d.a = a_shadow;
            r_d.n = n_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{a: '0, n: NMIN, pend: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign a_act     = r_q.a;
    assign n_act     = r_q.n;
    assign a_nxt     = r_d.a;
    assign load_done = r_q.done;
endmodule

// File: rtl/swc_seq.sv
module swc_seq
    import swc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SWC_N_W-1:0] n_act,
    input  logic [SWC_A_W-1:0] a_nxt,
    input  logic               dual_en,
    input  logic               standby,
    output logic [SWC_N_W-1:0] cnt_q,
    output logic               div_q,
    output logic               mod_q
);
    localparam logic [SWC_N_W-1:0] ONE = SWC_N_W'(1);

    seq_t s_q, s_d;
    logic wrap;

    always_comb begin
        wrap = s_q.cnt >= (n_act - ONE);
        s_d  = s_q;
        if (standby) begin
            s_d.cnt = '0;
            s_d.div = 1'b0;
            s_d.mod = 1'b0;
        end else begin
            s_d.cnt = wrap ? '0 : s_q.cnt + ONE;
            s_d.div = wrap;
            s_d.mod = dual_en && (s_d.cnt >= SWC_N_W'(a_nxt));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_q = s_q.cnt;
    assign div_q = s_q.div;
    assign mod_q = s_q.mod;
endmodule

// File: rtl/swc_edge.sv
module swc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic mod_rise,
    input  logic edge_fall,
    output logic mod_out
);
    logic fall_q, fall_d;

    always_comb begin
        fall_d = mod_rise;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= 1'b0;
        end else begin
            fall_q <= fall_d;
        end
    end

    assign mod_out = edge_fall ? fall_q : mod_rise;
endmodule

// File: rtl/swc_ctrl.sv
module swc_ctrl
    import swc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SWC_A_W-1:0] a_shadow,
    input  logic [SWC_N_W-1:0] n_shadow,
    input  logic               dual_en,
    input  logic               edge_fall,
    input  logic               standby,
    input  logic               sync_en,
    input  logic               load_req,
    output logic               mod_out,
    output logic               div_out,
    output logic               load_done
);
    logic [SWC_A_W-1:0] a_act;
    logic [SWC_A_W-1:0] a_nxt;
    logic [SWC_N_W-1:0] n_act;
    logic [SWC_N_W-1:0] cnt_q;
    logic               mod_rise;

    swc_reload u_reload (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_shadow  (a_shadow),
        .n_shadow  (n_shadow),
        .sync_en   (sync_en),
        .load_req  (load_req),
        .standby   (standby),
        .cnt_q     (cnt_q),
        .a_act     (a_act),
        .n_act     (n_act),
        .a_nxt     (a_nxt),
        .load_done (load_done)
    );

    swc_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .n_act   (n_act),
        .a_nxt   (a_nxt),
        .dual_en (dual_en),
        .standby (standby),
        .cnt_q   (cnt_q),
        .div_q   (div_out),
        .mod_q   (mod_rise)
    );

    swc_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .mod_rise  (mod_rise),
        .edge_fall (edge_fall),
        .mod_out   (mod_out)
    );
endmodule

// File: rtl/swc_ctrl_chk.sv
module swc_ctrl_chk
    import swc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               standby,
    input logic               sync_en,
    input logic               dual_en,
    input logic               edge_fall,
    input logic               load_req,
    input logic               mod_out,
    input logic               div_out,
    input logic               load_done,
    input logic               mod_rise,
    input logic [SWC_N_W-1:0] cnt_q,
    input logic [SWC_A_W-1:0] a_act
);
    // R2: modulus high only once the swallow phase is over
    a_r2_mod_after_swallow: assert property (@(posedge clk) disable iff (!rst_n)
        mod_rise |-> (cnt_q >= SWC_N_W'(a_act)));

    // R2: divided pulse lasts exactly one clock (N >= 3)
    a_r2_div_single: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |=> !div_out);

    // R4: single mode or standby forces modulus low
    a_r4_single_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_en || standby) |=> !mod_rise);

    // R5: standby parks the sequencer
    a_r5_standby_park: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (cnt_q == '0 && !div_out && !mod_rise));

    // R6: rising-edge selection passes the registered value straight out
    a_r6_rise_path: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_fall |-> (mod_out == mod_rise));

    // R7: a completed load needs a request or a pending synchronous load
    a_r7_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> ($past(load_req) || $past(sync_en)));

    // R8: synchronous transfer lands at count one
    a_r8_sync_point: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done && $past(sync_en)) |-> (cnt_q == SWC_N_W'(2)));
endmodule

bind swc_ctrl swc_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby   (standby),
    .sync_en   (sync_en),
    .dual_en   (dual_en),
    .edge_fall (edge_fall),
    .load_req  (load_req),
    .mod_out   (mod_out),
    .div_out   (div_out),
    .load_done (load_done),
    .mod_rise  (mod_rise),
    .cnt_q     (cnt_q),
    .a_act     (a_act)
);

// File: tb/tb_swc_ctrl.sv
`timescale 1ns/100ps
module tb_swc_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  a_shadow = '0;
    logic [13:0] n_shadow = 14'd3;
    logic        dual_en = 1'b0;
    logic        edge_fall = 1'b0;
    logic        standby = 1'b0;
    logic        sync_en = 1'b0;
    logic        load_req = 1'b0;
    logic        mod_out, div_out, load_done;

    int    errors = 0;
    int    checks = 0;
    string phase = "R1";
    bit    finished = 1'b0;

    // reference model state
    int m_cnt = 0, m_a = 0, m_n = 3, nc = 0, nn = 3;
    bit m_pend = 0, m_mod = 0, m_mod_old = 0, m_div = 0, m_done = 0, xf = 0;

    always #2 clk = ~clk;

    swc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .a_shadow(a_shadow), .n_shadow(n_shadow),
        .dual_en(dual_en), .edge_fall(edge_fall), .standby(standby),
        .sync_en(sync_en), .load_req(load_req), .mod_out(mod_out),
        .div_out(div_out), .load_done(load_done)
    );

    task automatic chk(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", phase, what, act, exp, $time);
        end
    endtask

    task automatic step(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic pulse_load;
        load_req = 1'b1;
        step(1);
        load_req = 1'b0;
    endtask

    // behavioural reference, compared every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_a = 0; m_n = 3; m_pend = 0;
            m_mod = 0; m_mod_old = 0; m_div = 0; m_done = 0;
        end else begin
            nn = (int'(n_shadow) < 3) ? 3 : int'(n_shadow);
            xf = sync_en ? (m_pend && m_cnt == 1 && !standby) : load_req;
            nc = standby ? 0 : ((m_cnt >= m_n - 1) ? 0 : m_cnt + 1);
            m_div = !standby && (m_cnt >= m_n - 1);
            if (xf) begin
                m_a = int'(a_shadow);
                m_n = nn;
            end
            m_pend = sync_en && (load_req || (m_pend && !xf));
            m_mod_old = m_mod;
            m_mod = dual_en && !standby && (nc >= m_a);
            m_cnt = nc;
            m_done = xf;
            #0.5;
            chk("mod before fall edge (R6)", mod_out, edge_fall ? m_mod_old : m_mod);
            #2.5;
            chk("mod after fall edge", mod_out, m_mod);
            chk("div_out", div_out, m_div);
            chk("load_done", load_done, m_done);
        end
    end

    task automatic load_async(input int a, input int n);
        a_shadow = 7'(a);
        n_shadow = 14'(n);
        pulse_load();
    endtask

    initial begin
        #1;
        chk("reset mod", mod_out, 1'b0);
        chk("reset div", div_out, 1'b0);
        chk("reset done", load_done, 1'b0);
        step(3);
        rst_n = 1'b1;

        phase = "R1";   step(12);

        phase = "R2";   dual_en = 1'b1; load_async(2, 5); step(25);
        load_async(5, 9); step(30);

        phase = "R3";   load_async(0, 4); step(16);

        phase = "R4";   dual_en = 1'b0; load_async(2, 6); step(20);

        phase = "R5";   dual_en = 1'b1; load_async(3, 7); step(4);
        standby = 1'b1; step(7);
        standby = 1'b0; step(20);

        phase = "R6";   edge_fall = 1'b1; step(24);
        load_async(1, 3); step(12);
        edge_fall = 1'b0; step(6);

        phase = "R7";   load_async(4, 11); step(3);
        load_async(2, 8); pulse_load(); step(20);

        phase = "R8";   sync_en = 1'b1; a_shadow = 7'd6; n_shadow = 14'd10;
        step(3); pulse_load(); step(30);
        a_shadow = 7'd1; n_shadow = 14'd4; pulse_load();
        standby = 1'b1; step(9);
        standby = 1'b0; step(20);
        sync_en = 1'b0;

        phase = "R9";   load_async(0, 1); step(12);
        load_async(0, 0); step(9);

        phase = "R10";  load_async(3, 20); step(15);
        load_async(2, 4); step(16);

        step(2);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule